// File: doc/BRIEF.md
# VT2 Transmit Pointer Generator

This block builds the four tributary pointer bytes of a 2 Mbit/s virtual tributary on the transmit side. It holds a pointer in the range 0 to 139 and, once per superframe, decides whether that superframe is plain, carries a positive or a negative justification, or announces a new pointer value with the new-data flag. The first and second pointer bytes carry a 16-bit word made of a flag nibble, a size field and the pointer. A justification is signalled by inverting either the increment bits or the decrement bits of the pointer. The third pointer byte and the byte that follows it are the justification opportunities. For each of them the block reports whether the slot is filled by the block or left to payload data.

A framer drives one strobe per pointer-related byte slot, together with a slot code. The V1 slot opens a superframe. Increment, decrement and load requests are single-cycle pulses. They stay pending until the block acts on them. Increments and decrements are spaced at least four superframes apart. When an adjustment would move the pointer across the 139/0 boundary, the block sends the target value as a new-data-flag load instead of inverting bits. While the alarm request is high, every generated byte is all ones and an alarm output tells the framer to overwrite the whole tributary.

Top module: `vt_ptr_gen`

## Requirements
- R1: After reset, the outputs vb_vld, vb_byte, vb_payload and ais_all are 0, the pointer is 0, and the first superframe sends the word 0x6800.
- R2: The V1/V2 word is sent as V1 = bits [15:8] and V2 = bits [7:0]. Its layout is flag [15:12] (0110 normal, 1001 new data), size [11:10] = 10 and pointer [9:0]. Pointer bits 9, 7, 5, 3, 1 are increment bits and bits 8, 6, 4, 2, 0 are decrement bits. V1, V2 and V4 slots always have vb_payload = 0, and the pointer never exceeds 139.
- R3: A serviced increment sends the old pointer with the increment bits inverted. The V3 byte and the byte after V3 both carry the stuff default with vb_payload = 0. The next superframe sends pointer+1 with the normal flag.
- R4: A serviced decrement sends the old pointer with the decrement bits inverted. The V3 slot and the byte after V3 have vb_payload = 1 and byte 0x00. The next superframe sends pointer-1 with the normal flag.
- R5: An increment at pointer 139 sends flag 1001 with pointer 0, leaves the justification slots as in a plain superframe, and the pointer becomes 0.
- R6: A decrement at pointer 0 sends flag 1001 with pointer 139, leaves the justification slots as in a plain superframe, and the pointer becomes 139.
- R7: An increment or decrement is serviced no earlier than four superframes after the previous serviced adjustment or load. Until then the request stays pending.
- R8: While ais_req is high, every strobed slot outputs 0xFF with vb_payload = 0 and ais_all is 1. A superframe that opens with ais_req high makes no adjustment or load, and pending requests stay pending.
- R9: Outside the alarm, the V4 slot carries oh_dflt.
- R10: In a plain superframe, V3 carries stuff_dflt with vb_payload = 0, and the byte after V3 has vb_payload = 1 and byte 0x00.
- R11: A load with a value of 139 or less is sent at the next superframe as flag 1001 with that pointer, takes priority over increment and decrement, ignores spacing, and restarts the spacing window. A load above 139 is discarded.
- R12: When both an increment and a decrement are pending, the increment is serviced first and the decrement stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_stb | input | 1 | One-cycle strobe for a pointer-related byte slot |
| slot_kind | input | 3 | Slot code: 0 V1, 1 V2, 2 V3, 3 byte after V3, 4 V4 |
| inc_req | input | 1 | Increment request pulse |
| dec_req | input | 1 | Decrement request pulse |
| load_req | input | 1 | New-pointer load pulse |
| load_ptr | input | 10 | Pointer value for a load |
| ais_req | input | 1 | Alarm-indication request level |
| stuff_dflt | input | 8 | Fixed-stuff default byte |
| oh_dflt | input | 8 | V4 default byte |
| vb_vld | output | 1 | Output byte valid, one cycle after the strobe |
| vb_byte | output | 8 | Generated byte |
| vb_payload | output | 1 | Slot is left to payload data |
| ais_all | output | 1 | Overwrite the whole tributary with ones |

## Verification
The bench builds the block with its default parameters: a 10-bit pointer, a maximum of 139 and a four-superframe spacing. With these values, directed loads can reach both wrap points in a few superframes, and the spacing window stays short, so it opens and closes many times in a short run. Random request pulses, load values above and below 139, alarm windows and changing default bytes are mixed with directed cases. Together they cover pending increments and decrements that collide, and loads that restart the window.

// File: rtl/vtpg_pkg.sv
package vtpg_pkg;
  typedef enum logic [2:0] {
    SL_V1 = 3'd0,
    SL_V2 = 3'd1,
    SL_V3 = 3'd2,
    SL_PJ = 3'd3,
    SL_V4 = 3'd4
  } slot_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_INC  = 2'd1,
    ACT_DEC  = 2'd2,
    ACT_NDF  = 2'd3
  } act_e;

  localparam logic [3:0] NDF_OFF = 4'b0110;
  localparam logic [3:0] NDF_ON  = 4'b1001;
endpackage

// File: rtl/vtpg_req_track.sv
module vtpg_req_track #(
  parameter int PTR_W   = 10,
  parameter int PTR_MAX = 139,
  parameter int GAP_SF  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_req,
  input  logic             dec_req,
  input  logic             load_req,
  input  logic [PTR_W-1:0] load_ptr,
  input  logic             sf_start,
  input  logic             take_inc,
  input  logic             take_dec,
  input  logic             take_load,
  output logic             inc_pend,
  output logic             dec_pend,
  output logic             load_pend,
  output logic [PTR_W-1:0] load_val,
  output logic             gap_open
);
  localparam int GAP_W = $clog2(GAP_SF + 1);
  localparam logic [GAP_W-1:0] GAP_FULL = GAP_W'(GAP_SF);

  logic [GAP_W-1:0] gap_cnt;
  logic             load_ok;

  assign load_ok  = load_req && (load_ptr <= PTR_W'(PTR_MAX));
  assign gap_open = (gap_cnt >= GAP_FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      inc_pend  <= 1'b0;
      dec_pend  <= 1'b0;
      load_pend <= 1'b0;
      load_val  <= '0;
    end else begin
      inc_pend  <= (inc_pend & ~take_inc) | inc_req;
      dec_pend  <= (dec_pend & ~take_dec) | dec_req;
      load_pend <= (load_pend & ~take_load) | load_ok;
      if (load_ok) load_val <= load_ptr;
    end
  end

  // spacing window counted in superframes since the last action
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt <= GAP_FULL;
    end else if (sf_start) begin
      if (take_inc || take_dec || take_load) gap_cnt <= GAP_W'(1);
      else if (gap_cnt < GAP_FULL)           gap_cnt <= gap_cnt + GAP_W'(1);
    end
  end
endmodule

// File: rtl/vtpg_ptr_calc.sv
module vtpg_ptr_calc
  import vtpg_pkg::*;
#(
  parameter int          PTR_W   = 10,
  parameter int          PTR_MAX = 139,
  parameter logic [1:0]  SS_CODE = 2'b10,
  localparam int         WORD_W  = PTR_W + 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sf_start,
  input  logic              ais,
  input  logic              load_pend,
  input  logic [PTR_W-1:0]  load_val,
  input  logic              inc_pend,
  input  logic              dec_pend,
  input  logic              gap_open,
  output logic              take_load,
  output logic              take_inc,
  output logic              take_dec,
  output act_e              act_q,
  output logic [WORD_W-1:0] word_n,
  output logic [WORD_W-1:0] word_q,
  output logic [PTR_W-1:0]  cur_ptr
);
  function automatic logic [PTR_W-1:0] bit_mask(input bit inc_side);
    logic [PTR_W-1:0] m;
    for (int b = 0; b < PTR_W; b++) m[b] = ((((PTR_W - 1 - b) % 2) == 0) == inc_side);
    return m;
  endfunction

  localparam logic [PTR_W-1:0] I_MASK = bit_mask(1'b1);
  localparam logic [PTR_W-1:0] D_MASK = bit_mask(1'b0);
  localparam logic [PTR_W-1:0] TOP    = PTR_W'(PTR_MAX);

  act_e             act_n;
  logic [PTR_W-1:0] ptr_n;
  logic [PTR_W-1:0] tx_ptr;
  logic [3:0]       ndf_n;

  always_comb begin
    act_n     = ACT_NONE;
    ptr_n     = cur_ptr;
    tx_ptr    = cur_ptr;
    ndf_n     = NDF_OFF;
    take_load = 1'b0;
    take_inc  = 1'b0;
    take_dec  = 1'b0;
    if (sf_start && !ais) begin
      if (load_pend) begin
        take_load = 1'b1;
        act_n     = ACT_NDF;
        ptr_n     = load_val;
        tx_ptr    = load_val;
        ndf_n     = NDF_ON;
      end else if (gap_open && inc_pend) begin
        take_inc = 1'b1;
        if (cur_ptr == TOP) begin
          act_n  = ACT_NDF;
          ptr_n  = '0;
          tx_ptr = '0;
          ndf_n  = NDF_ON;
        end else begin
          act_n  = ACT_INC;
          ptr_n  = cur_ptr + PTR_W'(1);
          tx_ptr = cur_ptr ^ I_MASK;
        end
      end else if (gap_open && dec_pend) begin
        take_dec = 1'b1;
        if (cur_ptr == '0) begin
          act_n  = ACT_NDF;
          ptr_n  = TOP;
          tx_ptr = TOP;
          ndf_n  = NDF_ON;
        end else begin
          act_n  = ACT_DEC;
          ptr_n  = cur_ptr - PTR_W'(1);
          tx_ptr = cur_ptr ^ D_MASK;
        end
      end
    end
    word_n = {ndf_n, SS_CODE, tx_ptr};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_ptr <= '0;
      act_q   <= ACT_NONE;
      word_q  <= {NDF_OFF, SS_CODE, {PTR_W{1'b0}}};
    end else if (sf_start) begin
      cur_ptr <= ptr_n;
      act_q   <= act_n;
      word_q  <= word_n;
    end
  end
endmodule

// File: rtl/vtpg_byte_mux.sv
module vtpg_byte_mux
  import vtpg_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_stb,
  input  slot_e             kind,
  input  logic              ais,
  input  act_e              act,
  input  logic [WORD_W-1:0] word_n,
  input  logic [WORD_W-1:0] word_q,
  input  logic [BYTE_W-1:0] stuff_dflt,
  input  logic [BYTE_W-1:0] oh_dflt,
  output logic              vb_vld,
  output logic [BYTE_W-1:0] vb_byte,
  output logic              vb_payload,
  output logic              ais_all
);
  logic [BYTE_W-1:0] byte_c;
  logic              pay_c;

  always_comb begin
    byte_c = '0;
    pay_c  = 1'b0;
    if (ais) begin
      byte_c = '1;
    end else begin
      case (kind)
        SL_V1:   byte_c = word_n[WORD_W-1 -: BYTE_W];
        SL_V2:   byte_c = word_q[BYTE_W-1:0];
        SL_V3: begin
          pay_c  = (act == ACT_DEC);
          byte_c = pay_c ? '0 : stuff_dflt;
        end
        SL_PJ: begin
          pay_c  = (act != ACT_INC);
          byte_c = pay_c ? '0 : stuff_dflt;
        end
        SL_V4:   byte_c = oh_dflt;
        default: byte_c = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vb_vld     <= 1'b0;
      vb_byte    <= '0;
      vb_payload <= 1'b0;
      ais_all    <= 1'b0;
    end else begin
      vb_vld     <= slot_stb;
      ais_all    <= ais;
      if (slot_stb) begin
        vb_byte    <= byte_c;
        vb_payload <= pay_c;
      end
    end
  end
endmodule

// File: rtl/vt_ptr_gen.sv
module vt_ptr_gen
  import vtpg_pkg::*;
#(
  parameter int PTR_W   = 10,
  parameter int PTR_MAX = 139,
  parameter int GAP_SF  = 4,
  parameter int BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_stb,
  input  logic [2:0]        slot_kind,
  input  logic              inc_req,
  input  logic              dec_req,
  input  logic              load_req,
  input  logic [PTR_W-1:0]  load_ptr,
  input  logic              ais_req,
  input  logic [BYTE_W-1:0] stuff_dflt,
  input  logic [BYTE_W-1:0] oh_dflt,
  output logic              vb_vld,
  output logic [BYTE_W-1:0] vb_byte,
  output logic              vb_payload,
  output logic              ais_all
);
  localparam int WORD_W = PTR_W + 6;

  slot_e             kind;
  logic              sf_start;
  logic              take_inc, take_dec, take_load;
  logic              inc_pend, dec_pend, load_pend, gap_open;
  logic [PTR_W-1:0]  load_val;
  logic [PTR_W-1:0]  cur_ptr;
  act_e              act_q;
  logic [WORD_W-1:0] word_n, word_q;

  assign kind     = slot_e'(slot_kind);
  assign sf_start = slot_stb && (kind == SL_V1);

  vtpg_req_track #(.PTR_W(PTR_W), .PTR_MAX(PTR_MAX), .GAP_SF(GAP_SF)) u_track (
    .clk(clk), .rst(rst),
    .inc_req(inc_req), .dec_req(dec_req), .load_req(load_req), .load_ptr(load_ptr),
    .sf_start(sf_start),
    .take_inc(take_inc), .take_dec(take_dec), .take_load(take_load),
    .inc_pend(inc_pend), .dec_pend(dec_pend), .load_pend(load_pend),
    .load_val(load_val), .gap_open(gap_open)
  );

  vtpg_ptr_calc #(.PTR_W(PTR_W), .PTR_MAX(PTR_MAX)) u_calc (
    .clk(clk), .rst(rst), .sf_start(sf_start), .ais(ais_req),
    .load_pend(load_pend), .load_val(load_val),
    .inc_pend(inc_pend), .dec_pend(dec_pend), .gap_open(gap_open),
    .take_load(take_load), .take_inc(take_inc), .take_dec(take_dec),
    .act_q(act_q), .word_n(word_n), .word_q(word_q), .cur_ptr(cur_ptr)
  );

  vtpg_byte_mux #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_mux (
    .clk(clk), .rst(rst), .slot_stb(slot_stb), .kind(kind), .ais(ais_req),
    .act(act_q), .word_n(word_n), .word_q(word_q),
    .stuff_dflt(stuff_dflt), .oh_dflt(oh_dflt),
    .vb_vld(vb_vld), .vb_byte(vb_byte), .vb_payload(vb_payload), .ais_all(ais_all)
  );
endmodule

// File: rtl/vt_ptr_gen_chk.sv
module vt_ptr_gen_chk #(
  parameter int PTR_W   = 10,
  parameter int PTR_MAX = 139,
  parameter int GAP_SF  = 4,
  parameter int BYTE_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              slot_stb,
  input logic [2:0]        slot_kind,
  input logic              ais_req,
  input logic [BYTE_W-1:0] oh_dflt,
  input logic              vb_vld,
  input logic [BYTE_W-1:0] vb_byte,
  input logic              vb_payload,
  input logic              ais_all,
  input logic              take_inc,
  input logic              take_dec,
  input logic              take_load,
  input logic [PTR_W-1:0]  cur_ptr
);
  localparam int GAP_W = $clog2(GAP_SF + 1);

  logic [GAP_W-1:0] sf_seen;
  logic             sf_edge;

  assign sf_edge = slot_stb && (slot_kind == 3'd0);

  always_ff @(posedge clk) begin
    if (rst) sf_seen <= GAP_W'(GAP_SF);
    else if (sf_edge) begin
      if (take_inc || take_dec || take_load) sf_seen <= GAP_W'(1);
      else if (sf_seen < GAP_W'(GAP_SF))     sf_seen <= sf_seen + GAP_W'(1);
    end
  end

  p_spacing_r7: assert property (@(posedge clk) disable iff (rst)
    (take_inc || take_dec) |-> (sf_seen >= GAP_W'(GAP_SF)));

  p_ptr_range_r2: assert property (@(posedge clk) disable iff (rst)
    cur_ptr <= PTR_W'(PTR_MAX));

  p_ctrl_slots_r2: assert property (@(posedge clk) disable iff (rst)
    (slot_stb && (slot_kind == 3'd0 || slot_kind == 3'd1 || slot_kind == 3'd4)) |=> !vb_payload);

  p_ais_ones_r8: assert property (@(posedge clk) disable iff (rst)
    (slot_stb && ais_req) |=> (vb_vld && vb_byte == '1 && !vb_payload && ais_all));

  p_v4_dflt_r9: assert property (@(posedge clk) disable iff (rst)
    (slot_stb && slot_kind == 3'd4 && !ais_req) |=> (vb_byte == $past(oh_dflt)));

  p_one_take_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({take_inc, take_dec, take_load}));
endmodule

bind vt_ptr_gen vt_ptr_gen_chk #(
  .PTR_W(PTR_W), .PTR_MAX(PTR_MAX), .GAP_SF(GAP_SF), .BYTE_W(BYTE_W)
) u_chk (
  .clk(clk), .rst(rst), .slot_stb(slot_stb), .slot_kind(slot_kind),
  .ais_req(ais_req), .oh_dflt(oh_dflt),
  .vb_vld(vb_vld), .vb_byte(vb_byte), .vb_payload(vb_payload), .ais_all(ais_all),
  .take_inc(take_inc), .take_dec(take_dec), .take_load(take_load),
  .cur_ptr(cur_ptr)
);

// File: tb/vt_ptr_gen_bench.sv
module vt_ptr_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slot_stb = 1'b0;
  logic [2:0] slot_kind = 3'd0;
  logic       inc_req = 1'b0, dec_req = 1'b0, load_req = 1'b0;
  logic [9:0] load_ptr = '0;
  logic       ais_req = 1'b0;
  logic [7:0] stuff_dflt = 8'h5A, oh_dflt = 8'hC3;
  logic       vb_vld, vb_payload, ais_all;
  logic [7:0] vb_byte;

  int checks = 0;
  int fails  = 0;

  int m_ptr = 0, m_gap = 4, m_ldv = 0;
  bit m_inc = 0, m_dec = 0, m_ld = 0, first_sf = 1;

  always #5 clk = ~clk;

  vt_ptr_gen u_vt_ptr_gen (
    .clk(clk), .rst(rst), .slot_stb(slot_stb), .slot_kind(slot_kind),
    .inc_req(inc_req), .dec_req(dec_req), .load_req(load_req), .load_ptr(load_ptr),
    .ais_req(ais_req), .stuff_dflt(stuff_dflt), .oh_dflt(oh_dflt),
    .vb_vld(vb_vld), .vb_byte(vb_byte), .vb_payload(vb_payload), .ais_all(ais_all)
  );

  task automatic chk(input int got, input int exp, input string tag, input string what);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
    end
  endtask

  task automatic do_slot(input int k);
    @(negedge clk);
    slot_stb  = 1'b1;
    slot_kind = 3'(k);
    @(negedge clk);
    slot_stb  = 1'b0;
  endtask

  task automatic pulse_inc();
    @(negedge clk); inc_req = 1'b1; @(negedge clk); inc_req = 1'b0; m_inc = 1;
  endtask
  task automatic pulse_dec();
    @(negedge clk); dec_req = 1'b1; @(negedge clk); dec_req = 1'b0; m_dec = 1;
  endtask
  task automatic pulse_load(input int v);
    @(negedge clk); load_req = 1'b1; load_ptr = 10'(v);
    @(negedge clk); load_req = 1'b0;
    if (v <= 139) begin m_ld = 1; m_ldv = v; end
  endtask

  function automatic int mk_word(input bit ndf, input int p);
    return ((ndf ? 4'b1001 : 4'b0110) << 12) | (2 << 10) | (p & 10'h3FF);
  endfunction

  task automatic run_sf();
    bit    a = ais_req;
    int    act = 0;
    int    tx = m_ptr, newp = m_ptr;
    bit    ndf = 0, took = 0;
    string tg = first_sf ? "R1" : "R10";
    int    w, eb, ep;
    if (!a) begin
      if (m_ld) begin
        m_ld = 0; took = 1; act = 3; ndf = 1; tx = m_ldv; newp = m_ldv; tg = "R11";
      end else if (m_inc && m_gap >= 4) begin
        tg = m_dec ? "R12" : "R3";
        m_inc = 0; took = 1;
        if (m_ptr == 139) begin act = 3; ndf = 1; tx = 0; newp = 0; tg = "R5"; end
        else begin act = 1; tx = m_ptr ^ 10'h2AA; newp = m_ptr + 1; end
      end else if (m_dec && m_gap >= 4) begin
        m_dec = 0; took = 1; tg = "R4";
        if (m_ptr == 0) begin act = 3; ndf = 1; tx = 139; newp = 139; tg = "R6"; end
        else begin act = 2; tx = m_ptr ^ 10'h155; newp = m_ptr - 1; end
      end else if (m_inc || m_dec) tg = "R7";
    end else tg = "R8";
    if (took) m_gap = 1; else if (m_gap < 4) m_gap++;
    first_sf = 0;
    w = mk_word(ndf, tx);

    do_slot(0);
    chk(vb_byte, a ? 8'hFF : (w >> 8), tg, "V1 byte");
    chk(vb_payload, 0, "R2", "V1 payload");
    do_slot(1);
    chk(vb_byte, a ? 8'hFF : (w & 8'hFF), tg, "V2 byte");
    do_slot(2);
    ep = a ? 0 : (act == 2);
    eb = a ? 8'hFF : (ep ? 0 : stuff_dflt);
    chk(vb_byte, eb, tg, "V3 byte");
    chk(vb_payload, ep, tg, "V3 payload");
    do_slot(3);
    ep = a ? 0 : (act != 1);
    eb = a ? 8'hFF : (ep ? 0 : stuff_dflt);
    chk(vb_byte, eb, tg, "post-V3 byte");
    chk(vb_payload, ep, tg, "post-V3 payload");
    do_slot(4);
    chk(vb_byte, a ? 8'hFF : oh_dflt, a ? "R8" : "R9", "V4 byte");
    chk(vb_vld, 1, "R9", "valid");
    if (a) chk(ais_all, 1, "R8", "alarm out");
    m_ptr = newp;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(vb_vld, 0, "R1", "reset valid");
    chk(vb_byte, 0, "R1", "reset byte");
    chk(ais_all, 0, "R1", "reset alarm");
    run_sf();

    // increment then spacing hold-off
    pulse_inc(); run_sf();
    pulse_inc(); repeat (4) run_sf();
    // load in range, then out-of-range load ignored
    pulse_load(139); run_sf();
    pulse_load(200); run_sf();
    repeat (3) run_sf();
    // wrap 139 -> 0
    pulse_inc(); repeat (2) run_sf();
    // wrap 0 -> 139
    repeat (3) run_sf();
    pulse_dec(); repeat (2) run_sf();
    // plain decrement
    pulse_dec(); repeat (5) run_sf();
    // both pending
    pulse_inc(); pulse_dec(); repeat (9) run_sf();
    // alarm holds requests
    ais_req = 1'b1; pulse_inc(); repeat (2) run_sf();
    ais_req = 1'b0; repeat (3) run_sf();

    // random mix
    for (int n = 0; n < 120; n++) begin
      int r = $urandom_range(0, 99);
      if (r < 20) pulse_inc();
      else if (r < 40) pulse_dec();
      else if (r < 48) pulse_load($urandom_range(0, 200));
      else if (r < 52) pulse_load($urandom_range(0, 1) ? 0 : 139);
      ais_req = ($urandom_range(0, 9) == 0);
      stuff_dflt = 8'($urandom);
      oh_dflt    = 8'($urandom);
      run_sf();
    end
    ais_req = 1'b0;

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule